// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Controller

This block is the target-side read engine of a two-wire serial byte memory. It does not sample the bus itself. A synchronizing front end hands it one-cycle events: a start (or repeated start), a stop, a complete byte clocked in from the controller, and the acknowledge bit the controller returned after a byte the memory sent. In return the block raises `ack_req` when the front end should pull the line low in the ninth clock. It raises `tx_en` with `tx_data` while it has a byte to shift out. While both are low, the data line is released.

Three read forms share one address counter. A current-address read is a start and a read select. A random read first sends a write-type select and two address bytes, then a repeated start and a read select. A sequential read is either of these, with the controller acknowledging each byte so that the next one follows. The array contents are fixed by a parameterised fill function, so the read path can be observed without a write path.

Top module: `twi_rd_slave`

## Requirements
- R1: After reset, `ack_req` and `tx_en` are low and the address counter holds 0.
- R2: A select byte is laid out as code in bits 7:1 and direction in bit 0 (1 = read). It is accepted when its code equals `DEV_CODE` in every bit set in `SEL_MASK`. `ack_req` rises one cycle after an accepted select byte. It falls on the next event of any kind.
- R3: After an accepted write select, the next two bytes are acknowledged. They are taken as the address, high byte first. The counter loads the low `ADDR_W` bits of that 16-bit value.
- R4: After the address bytes, a repeated start followed by a read select whose 7 code bits equal those of the first select starts output at the loaded address.
- R5: In a repeated select following address bytes, a read select whose 7 code bits differ from the first select's is not acknowledged. No byte is output, and the counter keeps the loaded address.
- R6: A start followed by an accepted read select outputs the byte at the counter. Array location `a` holds `((a*37 + SEED) XOR (a >> 3)) mod 256`.
- R7: The counter advances by one after every output byte, whether or not the controller acknowledges it. After location `2**ADDR_W - 1` it wraps to 0.
- R8: If the controller acknowledges an output byte, the next byte is presented. If it does not, `tx_en` falls, and no further byte is output before the next start.
- R9: A stop releases the line and returns the block to idle. A stop straight after the address bytes keeps the loaded address for a later current-address read.
- R10: A select byte that fails the device match is not acknowledged. Every later byte and acknowledge is then ignored until the next start: no acknowledge, no output, and the counter is unchanged.
- R11: A byte that arrives after the two address bytes, with no repeated start, is not acknowledged and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte | input | 1 | A byte from the controller is complete (one-cycle pulse) |
| rx_byte | input | 8 | Byte value, valid with `ev_byte` |
| ev_mack | input | 1 | Controller acknowledge bit sampled after an output byte (pulse) |
| mack_ack | input | 1 | 1 = controller acknowledged, 0 = not acknowledged, valid with `ev_mack` |
| ack_req | output | 1 | Drive the acknowledge bit low |
| tx_en | output | 1 | A byte is being output on the data line |
| tx_data | output | 8 | Byte to output while `tx_en` is high |

## Verification
The bench builds the block with `ADDR_W = 6`, `DEV_CODE = 7'h51`, `SEL_MASK = 7'h7C` and `SEED = 43`. The 64-byte array lets short sequential reads cross the wrap from location 63 to 0. It also means random 16-bit addresses exercise the truncation of the high address bits. The two unmasked code bits let a repeated select pass the device match while differing from the first select. That is the only way to reach the cross-phase mismatch rule.

// File: rtl/twi_rd_pkg.sv
package twi_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_SEL,    // expecting a select byte
    ST_AHI,    // expecting high address byte
    ST_ALO,    // expecting low address byte
    ST_APEND,  // address loaded, waiting for repeated start or stop
    ST_READ,   // sourcing bytes
    ST_DRAIN,  // controller declined, waiting for stop/start
    ST_DEAF    // not addressed, ignore until start
  } rd_state_e;

  // Array fill rule: location a holds ((a*37 + seed) ^ (a >> 3)) mod 256
  function automatic logic [7:0] fill_byte(input int unsigned a, input int unsigned seed);
    int unsigned v;
    v = (a * 32'd37 + seed) ^ (a >> 3);
    return v[7:0];
  endfunction

  // Masked comparison of a 7-bit select code against the device code
  function automatic logic code_hit(input logic [6:0] code, input logic [6:0] dev,
                                    input logic [6:0] mask);
    return ((code ^ dev) & mask) == 7'd0;
  endfunction

endpackage

// File: rtl/twi_rd_array.sv
module twi_rd_array #(
  parameter int          ADDR_W = 10,
  parameter int unsigned SEED   = 43
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import twi_rd_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign cells[i] = fill_byte(32'(i), SEED);
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/twi_rd_addr_ctr.sv
module twi_rd_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] cnt
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return (32'(a) + 1 >= DEPTH) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= next_addr(cnt);
  end

endmodule

// File: rtl/twi_rd_seldec.sv
module twi_rd_seldec #(
  parameter logic [6:0] DEV_CODE = 7'h51,
  parameter logic [6:0] SEL_MASK = 7'h7C
) (
  input  logic [7:0] rx_byte,
  input  logic [6:0] held_code,
  output logic       dev_hit,
  output logic       is_read,
  output logic       same_code
);
  import twi_rd_pkg::*;

  assign dev_hit   = code_hit(rx_byte[7:1], DEV_CODE, SEL_MASK);
  assign is_read   = rx_byte[0];
  assign same_code = (rx_byte[7:1] == held_code);

endmodule

// File: rtl/twi_rd_slave.sv
module twi_rd_slave #(
  parameter int          ADDR_W   = 10,
  parameter logic [6:0]  DEV_CODE = 7'h51,
  parameter logic [6:0]  SEL_MASK = 7'h7C,
  parameter int unsigned SEED     = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_mack,
  input  logic       mack_ack,
  output logic       ack_req,
  output logic       tx_en,
  output logic [7:0] tx_data
);
  import twi_rd_pkg::*;

  rd_state_e         state, nxt;
  logic              chain_q;     // current select follows a completed address phase
  logic [6:0]        held_code;
  logic [7:0]        hi_q;
  logic              ack_q;
  logic [ADDR_W-1:0] cnt;

  // Prioritised events: stop > start > byte > acknowledge
  logic e_stop, e_start, e_byte, e_mack, any_ev;
  assign e_stop  = ev_stop;
  assign e_start = ev_start & ~ev_stop;
  assign e_byte  = ev_byte & ~ev_start & ~ev_stop;
  assign e_mack  = ev_mack & ~ev_byte & ~ev_start & ~ev_stop;
  assign any_ev  = e_stop | e_start | e_byte | e_mack;

  logic dev_hit, is_read, same_code;
  twi_rd_seldec #(.DEV_CODE(DEV_CODE), .SEL_MASK(SEL_MASK)) u_sel (
    .rx_byte(rx_byte), .held_code(held_code),
    .dev_hit(dev_hit), .is_read(is_read), .same_code(same_code)
  );

  // Named internal events
  logic sel_byte, sel_accept, rand_reject, addr_accept, byte_accept, ctr_load, ctr_step;
  assign sel_byte    = e_byte && (state == ST_SEL);
  assign rand_reject = sel_byte && chain_q && is_read && !same_code;
  assign sel_accept  = sel_byte && dev_hit && !rand_reject;
  assign addr_accept = e_byte && ((state == ST_AHI) || (state == ST_ALO));
  assign byte_accept = sel_accept || addr_accept;
  assign ctr_load    = e_byte && (state == ST_ALO);
  assign ctr_step    = e_mack && (state == ST_READ);

  always_comb begin
    nxt = state;
    if (e_stop)       nxt = ST_IDLE;
    else if (e_start) nxt = ST_SEL;
    else if (e_byte) begin
      case (state)
        ST_SEL:   nxt = !sel_accept ? ST_DEAF : (is_read ? ST_READ : ST_AHI);
        ST_AHI:   nxt = ST_ALO;
        ST_ALO:   nxt = ST_APEND;
        ST_APEND: nxt = ST_DEAF;
        default:  nxt = state;
      endcase
    end else if (ctr_step) nxt = mack_ack ? ST_READ : ST_DRAIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chain_q   <= 1'b0;
      held_code <= '0;
      hi_q      <= '0;
      ack_q     <= 1'b0;
    end else begin
      state <= nxt;
      if (e_stop)       chain_q <= 1'b0;
      else if (e_start) chain_q <= (state == ST_APEND);
      if (sel_accept)   held_code <= rx_byte[7:1];
      if (e_byte && state == ST_AHI) hi_q <= rx_byte;
      if (any_ev)       ack_q <= byte_accept;
    end
  end

  twi_rd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val(ADDR_W'({hi_q, rx_byte})), .step(ctr_step), .cnt(cnt)
  );

  twi_rd_array #(.ADDR_W(ADDR_W), .SEED(SEED)) u_mem (
    .rd_addr(cnt), .rd_data(tx_data)
  );

  assign ack_req = ack_q;
  assign tx_en   = (state == ST_READ);

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(ev_byte)); // R2
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_load |=> cnt == ADDR_W'({$past(hi_q), $past(rx_byte)})); // R3
  AST_REP_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    rand_reject |=> !tx_en && !ack_req); // R5
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_step |=> cnt == ADDR_W'($past(cnt) + 1'b1)); // R7
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_step && !mack_ack) |=> !tx_en); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !tx_en && !ack_req); // R9
  AST_DEAF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAF && !ev_start) |=> !tx_en && !ack_req); // R10

endmodule

// File: tb/twi_rd_slave_test.sv
`timescale 1ns/1ps
module twi_rd_slave_test;
  localparam int          AW    = 6;
  localparam int          DEPTH = 1 << AW;
  localparam logic [6:0]  DEV   = 7'h51;
  localparam int unsigned SEED  = 43;

  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_mack = 0, mack_ack = 0;
  logic [7:0] rx_byte = 0;
  logic ack_req, tx_en;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;
  bit done = 0;

  twi_rd_slave #(.ADDR_W(AW), .DEV_CODE(DEV), .SEL_MASK(7'h7C), .SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_mack(ev_mack), .mack_ack(mack_ack),
    .ack_req(ack_req), .tx_en(tx_en), .tx_data(tx_data));

  always #4 clk = ~clk;

  function automatic int model_byte(input int a);
    return ((a * 37 + SEED) % 256) ^ ((a / 8) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic p_start;
    @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
  endtask
  task automatic p_stop;
    @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask
  task automatic p_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk); rx_byte = b; ev_byte = 1; @(negedge clk); ev_byte = 0;
    chk(ack_req == exp_ack, tag, int'(ack_req), int'(exp_ack));
  endtask
  task automatic p_mack(input bit a);
    @(negedge clk); mack_ack = a; ev_mack = 1; @(negedge clk); ev_mack = 0;
  endtask

  task automatic check_released(input string tag);
    chk(!tx_en && !ack_req, tag, {tx_en, ack_req}, 0);
  endtask

  // Read n bytes; last one declined if nack_last
  task automatic read_seq(input int n, input bit nack_last);
    for (int i = 0; i < n; i++) begin
      chk(tx_en == 1'b1, "R8 tx_en during read", int'(tx_en), 1);
      chk(int'(tx_data) == model_byte(exp_cnt), "R6/R7 read data", int'(tx_data), model_byte(exp_cnt));
      p_mack(!(nack_last && i == n - 1));
      exp_cnt = (exp_cnt + 1) % DEPTH;
    end
    if (nack_last) chk(tx_en == 1'b0, "R8 release after decline", int'(tx_en), 0);
    else           chk(tx_en == 1'b1, "R8 next byte after acknowledge", int'(tx_en), 1);
  endtask

  task automatic current_read(input logic [6:0] code, input int n, input bit nack_last);
    p_start;
    p_byte({code, 1'b1}, 1'b1, "R2 read select acknowledged");
    read_seq(n, nack_last);
    p_stop;
    check_released("R9 stop releases");
  endtask

  task automatic set_addr(input logic [6:0] code, input int a16);
    p_start;
    p_byte({code, 1'b0}, 1'b1, "R2 write select acknowledged");
    p_byte(8'(a16 >> 8), 1'b1, "R3 high address acknowledged");
    p_byte(8'(a16), 1'b1, "R3 low address acknowledged");
    exp_cnt = a16 % DEPTH;
  endtask

  task automatic random_read(input logic [6:0] code, input int a16, input int n, input bit nack_last);
    set_addr(code, a16);
    p_start;
    p_byte({code, 1'b1}, 1'b1, "R4 repeated read select acknowledged");
    read_seq(n, nack_last);
    p_stop;
    check_released("R9 stop releases");
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    void'($urandom(32'd917));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_released("R1 reset state");
    current_read(DEV, 3, 1'b1);       // R1: begins at 0; R6 current read

    random_read(DEV, DEPTH - 2, 4, 1'b1);   // R7 wrap
    random_read(DEV, 16'hFFC1, 2, 1'b0);    // R3 truncation, R8 stop after acknowledge

    // R5: repeated select differs in unmasked code bits
    set_addr(DEV, 16'h0017);
    p_start;
    p_byte({DEV ^ 7'h02, 1'b1}, 1'b0, "R5 mismatched repeated select not acknowledged");
    chk(tx_en == 1'b0, "R5 no output", int'(tx_en), 0);
    p_stop;
    current_read(DEV, 1, 1'b1);       // R5 counter kept at 0x17

    // R10: wrong device code, then everything ignored until start
    p_start;
    p_byte({7'h31, 1'b1}, 1'b0, "R10 foreign select not acknowledged");
    p_mack(1'b1);
    check_released("R10 acknowledge ignored");
    p_byte({DEV, 1'b1}, 1'b0, "R10 own select ignored without start");
    chk(tx_en == 1'b0, "R10 no output", int'(tx_en), 0);
    p_stop;
    current_read(DEV, 1, 1'b1);       // R10 counter unchanged

    // R9: dummy write then stop keeps the address
    set_addr(DEV, 16'h0029);
    p_stop;
    check_released("R9 release after address phase");
    current_read(DEV, 2, 1'b1);

    // R11: data byte after address phase
    set_addr(DEV, 16'h0033);
    p_byte(8'hA5, 1'b0, "R11 data byte not acknowledged");
    p_stop;
    current_read(DEV, 1, 1'b1);

    // Constrained random reads
    for (int it = 0; it < 30; it++) begin
      logic [6:0] code;
      int n;
      code = DEV ^ 7'($urandom % 4);
      n = 1 + int'($urandom % 6);
      if ($urandom % 2 == 0) random_read(code, int'($urandom % 65536), n, ($urandom % 4) != 0);
      else                   current_read(code, n, ($urandom % 4) != 0);
    end

    finish_run;
  end
endmodule